// File: doc/BRIEF.md
# Indirect SDRAM Bank Configuration Unit

This block holds the configuration state of a four-bank memory controller and turns it into a live bank decode. Software reaches it through two ports. The selector port stores an internal register offset. The data window then reads or writes whichever internal register that offset names. The internal registers are:

- controller configuration and a read-only status word;
- two write-one-to-clear error-status words and an error-address word;
- refresh, power-management, timing and ECC-configuration words;
- ECC error status;
- one configuration word per bank.

Each bank word holds a base address, a power-of-two size code and an enable bit. While the controller enable bit is set, the block compares a system address against every enabled bank and reports a one-hot hit vector. Register writes commit on the clock edge and reads are combinational. The ECC interrupt is a flop that follows the zero/nonzero state of the ECC error-status word.

Top module: `sdram_cfg_unit`

## Requirements
- R1: A write with `portSel`=0 stores the full 32-bit `wrData` as the offset. A read with `portSel`=0 returns that offset. With `portSel`=1, reads and writes go to the internal register that the offset selects.
- R2: Reads at offset 0x80 (timing) return 0xFFFFFFFF whatever was written there. Any offset not listed in R3 to R12 (for example 0x04 or 0x50) also reads 0xFFFFFFFF.
- R3: The error-address word at 0x10 stores all 32 written bits. The error-status words at 0x00 and 0x08 reset to 0, and a write only clears the bits that are set in the data, so they read 0.
- R4: The configuration word at 0x20 resets to 0x00800000. A write keeps bits 31:21 and zeroes bits 20:0. Bit 31 is the controller enable.
- R5: The status word at 0x24 resets to 0 and ignores writes. When configuration bit 31 goes from 0 to 1, status bit 31 clears. When it goes from 1 to 0, status bit 31 sets.
- R6: When configuration bit 30 goes from 0 to 1, status bit 30 sets. When it goes from 1 to 0, status bit 30 clears. All other status bits stay 0.
- R7: Refresh (0x30) resets to 0x05F00000 and keeps written bits under mask 0x3FF80000. Power-management (0x34) resets to 0x07C00000 and reads as (write AND 0xF8000000) OR 0x07C00000. ECC configuration (0x94) resets to 0 and keeps bits under 0x00F00000.
- R8: Bank words 0 to 3 sit at offsets 0x40, 0x44, 0x48 and 0x4C. They reset to 0, and a write stores the data AND 0xFFDEE001. Bits 31:23 are the base, bits 19:17 the size code and bit 0 the enable.
- R9: `bankHit` bit i can be 1 only while configuration bit 31 and bank i's bit 0 are both set.
- R10: A bank covers the addresses from (base << 23) up to, but not including, (base << 23) + (4 MiB << code). Size code 7 never hits.
- R11: `bankHit` is one-hot or zero. When several banks cover an address, the lowest-numbered bank wins.
- R12: The ECC error status at 0x98 resets to 0 and stores the data AND 0xFFF0F000. `eccIrq` rises on the edge where that register goes from zero to nonzero. It falls on the edge where the register returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portSel | input | 1 | 0 selects the offset port, 1 selects the data window |
| wrEn | input | 1 | Write strobe for the selected port |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data of the selected port |
| decAddr | input | 32 | System address to decode |
| bankHit | output | 4 | One-hot bank hit vector |
| eccIrq | output | 1 | ECC error interrupt |

## Verification
Every register write takes effect at the clock edge that samples `wrEn`. The written value therefore shows on `rdData` during the next cycle, with no further delay, and `eccIrq` changes at that same edge. `bankHit` depends combinationally on `decAddr` and on the registers already committed, so it is valid in the same cycle the address is applied. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. For a read, the offset write has committed on the edge in between and the window value is then settled.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;
  localparam int CFG_BANKS  = 4;
  localparam int BANK_IDX_W = (CFG_BANKS > 1) ? $clog2(CFG_BANKS) : 1;
  localparam int DATA_W     = 32;

  localparam logic [DATA_W-1:0] OFF_ESR0   = 32'h00;
  localparam logic [DATA_W-1:0] OFF_ESR1   = 32'h08;
  localparam logic [DATA_W-1:0] OFF_EAR    = 32'h10;
  localparam logic [DATA_W-1:0] OFF_CFG    = 32'h20;
  localparam logic [DATA_W-1:0] OFF_STS    = 32'h24;
  localparam logic [DATA_W-1:0] OFF_REF    = 32'h30;
  localparam logic [DATA_W-1:0] OFF_PM     = 32'h34;
  localparam logic [DATA_W-1:0] OFF_BANK0  = 32'h40;
  localparam logic [DATA_W-1:0] OFF_TIM    = 32'h80;
  localparam logic [DATA_W-1:0] OFF_ECCCFG = 32'h94;
  localparam logic [DATA_W-1:0] OFF_ECCSTS = 32'h98;

  localparam logic [DATA_W-1:0] CFG_MASK    = 32'hFFE0_0000;
  localparam logic [DATA_W-1:0] REF_MASK    = 32'h3FF8_0000;
  localparam logic [DATA_W-1:0] PM_MASK     = 32'hF800_0000;
  localparam logic [DATA_W-1:0] PM_FORCE    = 32'h07C0_0000;
  localparam logic [DATA_W-1:0] ECCCFG_MASK = 32'h00F0_0000;
  localparam logic [DATA_W-1:0] ECCSTS_MASK = 32'hFFF0_F000;
  localparam logic [DATA_W-1:0] BANK_MASK   = 32'hFFDE_E001;

  localparam logic [DATA_W-1:0] CFG_RST = 32'h0080_0000;
  localparam logic [DATA_W-1:0] REF_RST = 32'h05F0_0000;
  localparam logic [DATA_W-1:0] PM_RST  = 32'h07C0_0000;

  typedef enum logic [3:0] {
    SEL_ESR0, SEL_ESR1, SEL_EAR, SEL_CFG, SEL_STS, SEL_REF, SEL_PM,
    SEL_BANK, SEL_ECCCFG, SEL_ECCSTS, SEL_ONES
  } rdSel_e;

  typedef struct packed {
    logic                  wrEsr0;
    logic                  wrEsr1;
    logic                  wrEar;
    logic                  wrCfg;
    logic                  wrRef;
    logic                  wrPm;
    logic                  wrEccCfg;
    logic                  wrEccSts;
    logic                  wrBank;
    logic [BANK_IDX_W-1:0] bankIdx;
    rdSel_e                rdSel;
  } strobes_t;
endpackage

// File: rtl/sdcfg_ctrl.sv
module sdcfg_ctrl
  import sdcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              portSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] offsetQ,
  output strobes_t          strb
);
  logic    winWr;
  rdSel_e  sel;
  logic    isBank;
  logic [BANK_IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN)                 offsetQ <= '0;
    else if (wrEn && !portSel) offsetQ <= wrData;
  end

  always_comb begin
    isBank = 1'b0;
    idx    = '0;
    for (int b = 0; b < CFG_BANKS; b++) begin
      if (offsetQ == OFF_BANK0 + 32'(4 * b)) begin
        isBank = 1'b1;
        idx    = BANK_IDX_W'(b);
      end
    end
  end

  always_comb begin
    if (isBank) sel = SEL_BANK;
    else begin
      unique case (offsetQ)
        OFF_ESR0:   sel = SEL_ESR0;
        OFF_ESR1:   sel = SEL_ESR1;
        OFF_EAR:    sel = SEL_EAR;
        OFF_CFG:    sel = SEL_CFG;
        OFF_STS:    sel = SEL_STS;
        OFF_REF:    sel = SEL_REF;
        OFF_PM:     sel = SEL_PM;
        OFF_ECCCFG: sel = SEL_ECCCFG;
        OFF_ECCSTS: sel = SEL_ECCSTS;
        default:    sel = SEL_ONES;
      endcase
    end
  end

  assign winWr = wrEn && portSel;

  always_comb begin
    strb          = '0;
    strb.rdSel    = sel;
    strb.bankIdx  = idx;
    strb.wrEsr0   = winWr && (sel == SEL_ESR0);
    strb.wrEsr1   = winWr && (sel == SEL_ESR1);
    strb.wrEar    = winWr && (sel == SEL_EAR);
    strb.wrCfg    = winWr && (sel == SEL_CFG);
    strb.wrRef    = winWr && (sel == SEL_REF);
    strb.wrPm     = winWr && (sel == SEL_PM);
    strb.wrEccCfg = winWr && (sel == SEL_ECCCFG);
    strb.wrEccSts = winWr && (sel == SEL_ECCSTS);
    strb.wrBank   = winWr && (sel == SEL_BANK);
  end

  // R1: an offset-port write is what the offset port reads back next cycle
  a_r1_offset_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !portSel) |=> (offsetQ == $past(wrData)));

  // R5: a status offset never produces a write strobe
  a_r5_status_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (offsetQ == OFF_STS) |-> !(strb.wrCfg || strb.wrBank || strb.wrEccSts));
endmodule

// File: rtl/sdcfg_datapath.sv
module sdcfg_datapath
  import sdcfg_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobes_t                        strb,
  input  logic [DATA_W-1:0]               wrData,
  output logic [DATA_W-1:0]               winData,
  output logic                            ctrlEn,
  output logic [CFG_BANKS-1:0][DATA_W-1:0] bankQ,
  output logic                            eccIrq
);
  logic [DATA_W-1:0] esr0Q, esr1Q, earQ, cfgQ, stsQ, refQ, pmQ, eccCfgQ, eccStsQ;
  logic [DATA_W-1:0] cfgNew, eccNew;

  assign cfgNew = wrData & CFG_MASK;
  assign eccNew = wrData & ECCSTS_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      esr0Q <= '0; esr1Q <= '0; earQ <= '0;
      refQ <= REF_RST; pmQ <= PM_RST; eccCfgQ <= '0;
    end else begin
      if (strb.wrEsr0)   esr0Q   <= esr0Q & ~wrData;
      if (strb.wrEsr1)   esr1Q   <= esr1Q & ~wrData;
      if (strb.wrEar)    earQ    <= wrData;
      if (strb.wrRef)    refQ    <= wrData & REF_MASK;
      if (strb.wrPm)     pmQ     <= (wrData & PM_MASK) | PM_FORCE;
      if (strb.wrEccCfg) eccCfgQ <= wrData & ECCCFG_MASK;
    end
  end

  // configuration and status with edge-driven status bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= CFG_RST;
      stsQ <= '0;
    end else if (strb.wrCfg) begin
      cfgQ <= cfgNew;
      if (!cfgQ[31] && cfgNew[31])      stsQ[31] <= 1'b0;
      else if (cfgQ[31] && !cfgNew[31]) stsQ[31] <= 1'b1;
      if (!cfgQ[30] && cfgNew[30])      stsQ[30] <= 1'b1;
      else if (cfgQ[30] && !cfgNew[30]) stsQ[30] <= 1'b0;
    end
  end

  // ECC error status and interrupt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eccStsQ <= '0;
      eccIrq  <= 1'b0;
    end else if (strb.wrEccSts) begin
      eccStsQ <= eccNew;
      if (eccStsQ == '0 && eccNew != '0)      eccIrq <= 1'b1;
      else if (eccStsQ != '0 && eccNew == '0) eccIrq <= 1'b0;
    end
  end

  for (genvar b = 0; b < CFG_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) bankQ[b] <= '0;
      else if (strb.wrBank && strb.bankIdx == BANK_IDX_W'(b))
        bankQ[b] <= wrData & BANK_MASK;
    end

    // R8: no stored bank bit lies outside the write mask
    a_r8_bank_mask: assert property (@(posedge clk) disable iff (!rstN)
      (bankQ[b] & ~BANK_MASK) == '0);
  end

  assign ctrlEn = cfgQ[31];

  always_comb begin
    unique case (strb.rdSel)
      SEL_ESR0:   winData = esr0Q;
      SEL_ESR1:   winData = esr1Q;
      SEL_EAR:    winData = earQ;
      SEL_CFG:    winData = cfgQ;
      SEL_STS:    winData = stsQ;
      SEL_REF:    winData = refQ;
      SEL_PM:     winData = pmQ;
      SEL_BANK:   winData = bankQ[strb.bankIdx];
      SEL_ECCCFG: winData = eccCfgQ;
      SEL_ECCSTS: winData = eccStsQ;
      default:    winData = '1;
    endcase
  end

  // R5: turning the controller off sets status bit 31
  a_r5_disable_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCfg && cfgQ[31] && !wrData[31]) |=> stsQ[31]);

  // R6: turning bit 30 on sets status bit 30
  a_r6_bit30_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCfg && !cfgQ[30] && wrData[30]) |=> stsQ[30]);

  // R4: low configuration bits stay clear after any write
  a_r4_cfg_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCfg |=> (cfgQ[20:0] == '0));

  // R12: a nonzero masked ECC write leaves the interrupt high
  a_r12_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEccSts && (wrData & ECCSTS_MASK) != '0) |=> eccIrq);

  // R12: a zero masked ECC write leaves the interrupt low
  a_r12_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEccSts && (wrData & ECCSTS_MASK) == '0) |=> !eccIrq);
endmodule

// File: rtl/sdcfg_bank_decode.sv
module sdcfg_bank_decode
  import sdcfg_pkg::*;
#(
  parameter int BASE_LSB = 23,
  parameter int CODE_LSB = 17,
  parameter int CODE_W   = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             ctrlEn,
  input  logic [CFG_BANKS-1:0][DATA_W-1:0] bankQ,
  input  logic [DATA_W-1:0]                decAddr,
  output logic [CFG_BANKS-1:0]             bankHit
);
  localparam int UNIT_LSB = BASE_LSB - 1;          // 4 MiB granule
  localparam int UNIT_W   = DATA_W - UNIT_LSB;
  localparam int CODE_BAD = (1 << CODE_W) - 1;

  logic [CFG_BANKS-1:0] cand;

  for (genvar b = 0; b < CFG_BANKS; b++) begin : g_cmp
    logic [UNIT_W:0]   diff;
    logic [CODE_W-1:0] code;
    logic [UNIT_W:0]   span;
    assign code = bankQ[b][CODE_LSB +: CODE_W];
    assign diff = {1'b0, decAddr[DATA_W-1:UNIT_LSB]}
                - {1'b0, bankQ[b][DATA_W-1:BASE_LSB], 1'b0};
    assign span = (UNIT_W+1)'(1) << code;
    assign cand[b] = ctrlEn && bankQ[b][0] && (int'(code) != CODE_BAD)
                     && !diff[UNIT_W] && (diff < span);
  end

  always_comb begin
    bankHit = '0;
    for (int b = CFG_BANKS - 1; b >= 0; b--) begin
      if (cand[b]) bankHit = CFG_BANKS'(1) << b;
    end
  end

  // R11: at most one bank reported
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankHit));

  // R9: no hit while the controller is disabled
  a_r9_gate: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |-> (bankHit == '0));
endmodule

// File: rtl/sdram_cfg_unit.sv
module sdram_cfg_unit
  import sdcfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 portSel,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [DATA_W-1:0]    decAddr,
  output logic [CFG_BANKS-1:0] bankHit,
  output logic                 eccIrq
);
  strobes_t                        strb;
  logic [DATA_W-1:0]               offsetQ, winData;
  logic                            ctrlEn;
  logic [CFG_BANKS-1:0][DATA_W-1:0] bankQ;

  sdcfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn),
    .wrData(wrData), .offsetQ(offsetQ), .strb(strb)
  );

  sdcfg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .winData(winData), .ctrlEn(ctrlEn), .bankQ(bankQ), .eccIrq(eccIrq)
  );

  sdcfg_bank_decode u_dec (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .bankQ(bankQ),
    .decAddr(decAddr), .bankHit(bankHit)
  );

  assign rdData = portSel ? winData : offsetQ;
endmodule

// File: tb/tb_sdram_cfg_unit.sv
`timescale 1ns/1ps
module tb_sdram_cfg_unit;
  logic        clk = 1'b0;
  logic        rstN, portSel, wrEn;
  logic [31:0] wrData, decAddr, rdData;
  logic [3:0]  bankHit;
  logic        eccIrq;

  int checks = 0;
  int errors = 0;

  logic [31:0] mEar, mCfg, mSts, mRef, mPm, mEccCfg, mEccSts;
  logic [31:0] mBank [4];
  logic        mIrq;

  always #2 clk = ~clk;

  sdram_cfg_unit dut (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .decAddr(decAddr), .bankHit(bankHit), .eccIrq(eccIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic logic [31:0] expRead(input logic [31:0] off);
    case (off)
      32'h00, 32'h08: return 32'h0;
      32'h10: return mEar;
      32'h20: return mCfg;
      32'h24: return mSts;
      32'h30: return mRef;
      32'h34: return mPm;
      32'h40: return mBank[0];
      32'h44: return mBank[1];
      32'h48: return mBank[2];
      32'h4C: return mBank[3];
      32'h94: return mEccCfg;
      32'h98: return mEccSts;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] expHit(input logic [31:0] a);
    for (int i = 0; i < 4; i++) begin
      longint lo, hi;
      int code;
      code = int'(mBank[i][19:17]);
      lo = longint'(mBank[i] & 32'hFF80_0000);
      hi = lo + (longint'(4194304) << code);
      if (mCfg[31] && mBank[i][0] && code != 7 && longint'(a) >= lo && longint'(a) < hi)
        return 4'(1 << i);
    end
    return 4'h0;
  endfunction

  task automatic modelWrite(input logic [31:0] off, input logic [31:0] v);
    logic [31:0] n;
    case (off)
      32'h10: mEar = v;
      32'h20: begin
        n = v & 32'hFFE0_0000;
        if (mCfg[31] != n[31]) mSts[31] = mCfg[31];
        if (mCfg[30] != n[30]) mSts[30] = n[30];
        mCfg = n;
      end
      32'h30: mRef = v & 32'h3FF8_0000;
      32'h34: mPm = (v & 32'hF800_0000) | 32'h07C0_0000;
      32'h40: mBank[0] = v & 32'hFFDE_E001;
      32'h44: mBank[1] = v & 32'hFFDE_E001;
      32'h48: mBank[2] = v & 32'hFFDE_E001;
      32'h4C: mBank[3] = v & 32'hFFDE_E001;
      32'h94: mEccCfg = v & 32'h00F0_0000;
      32'h98: begin
        mEccSts = v & 32'hFFF0_F000;
        mIrq = (mEccSts != 0);
      end
      default: ;
    endcase
  endtask

  task automatic wrOff(input logic [31:0] v);
    @(negedge clk);
    portSel = 1'b0; wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrReg(input logic [31:0] off, input logic [31:0] v);
    wrOff(off);
    portSel = 1'b1; wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(off, v);
  endtask

  task automatic rdChk(input string req, input logic [31:0] off);
    wrOff(off);
    portSel = 1'b1;
    #1;
    chk(req, rdData, expRead(off));
  endtask

  task automatic hitChk(input string req, input logic [31:0] a);
    @(negedge clk);
    decAddr = a;
    #1;
    chk(req, 32'(bankHit), 32'(expHit(a)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all-requirements actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] offs [15];
    int dummy;
    offs = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34, 32'h40,
             32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98, 32'h50};
    dummy = $urandom(32'h5EED_1234);
    mEar = 0; mCfg = 32'h0080_0000; mSts = 0; mRef = 32'h05F0_0000;
    mPm = 32'h07C0_0000; mEccCfg = 0; mEccSts = 0; mIrq = 0;
    for (int i = 0; i < 4; i++) mBank[i] = 0;
    rstN = 1'b0; portSel = 1'b0; wrEn = 1'b0; wrData = 0; decAddr = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset state
    #1;
    chk("R1 reset offset", rdData, 32'h0);
    chk("R12 reset irq", 32'(eccIrq), 32'h0);
    chk("R9 reset hit", 32'(bankHit), 32'h0);
    rdChk("R4 reset cfg", 32'h20);
    rdChk("R7 reset refresh", 32'h30);
    rdChk("R7 reset pm", 32'h34);
    rdChk("R5 reset status", 32'h24);
    rdChk("R8 reset bank2", 32'h48);
    rdChk("R2 timing ones", 32'h80);

    // R1 offset port
    wrOff(32'h1234_5678);
    portSel = 1'b0; #1;
    chk("R1 offset readback", rdData, 32'h1234_5678);
    rdChk("R2 unknown 0x04", 32'h04);
    rdChk("R2 unknown 0x50", 32'h50);
    wrReg(32'h80, 32'h0000_0000);
    rdChk("R2 timing after write", 32'h80);

    // R3
    wrReg(32'h10, 32'hDEAD_BEEF);
    rdChk("R3 error address", 32'h10);
    wrReg(32'h00, 32'hFFFF_FFFF);
    rdChk("R3 error status 0", 32'h00);
    rdChk("R3 error status 1", 32'h08);

    // R4 R5 R6
    wrReg(32'h20, 32'hFFFF_FFFF);
    rdChk("R4 cfg mask", 32'h20);
    rdChk("R6 status bit30 set", 32'h24);
    wrReg(32'h24, 32'hFFFF_FFFF);
    rdChk("R5 status write ignored", 32'h24);
    wrReg(32'h20, 32'h0000_0000);
    rdChk("R5 status bit31 on disable", 32'h24);
    chk("R5 status value", expRead(32'h24), 32'h8000_0000);
    wrReg(32'h20, 32'h8000_0000);
    rdChk("R5 status bit31 clear on enable", 32'h24);

    // R7
    wrReg(32'h30, 32'hFFFF_FFFF);
    rdChk("R7 refresh mask", 32'h30);
    wrReg(32'h34, 32'h0000_0000);
    rdChk("R7 pm forced bits", 32'h34);
    wrReg(32'h94, 32'hFFFF_FFFF);
    rdChk("R7 ecc cfg mask", 32'h94);

    // R8 and decode
    wrReg(32'h40, 32'hFFFF_FFFF);
    rdChk("R8 bank0 mask", 32'h40);
    wrReg(32'h40, 32'h0004_0001);   // base 0, 16 MiB
    wrReg(32'h44, 32'h0100_0001);   // base 16 MiB, 4 MiB
    wrReg(32'h48, 32'h020E_0001);   // size code 7
    wrReg(32'h4C, 32'h0006_0001);   // base 0, 32 MiB
    hitChk("R10 bank0 top", 32'h00FF_FFFF);
    chk("R10 bank0 expected", 32'(expHit(32'h00FF_FFFF)), 32'h1);
    hitChk("R11 bank1 over bank3", 32'h0100_0000);
    hitChk("R10 bank1 top of 4MiB", 32'h013F_FFFF);
    hitChk("R11 bank3 past bank1", 32'h0140_0000);
    hitChk("R10 code7 no hit", 32'h0200_0000);
    hitChk("R11 bank0 over bank3", 32'h0000_0010);
    chk("R11 bank0 expected", 32'(expHit(32'h0000_0010)), 32'h1);
    wrReg(32'h40, 32'h0004_0000);
    hitChk("R9 bank0 disabled", 32'h0000_0010);
    wrReg(32'h20, 32'h0000_0000);
    hitChk("R9 controller disabled", 32'h0100_0000);
    chk("R9 disabled expected", 32'(expHit(32'h0100_0000)), 32'h0);

    // R12
    wrReg(32'h98, 32'h000F_0FFF);
    #1; chk("R12 masked zero no irq", 32'(eccIrq), 32'h0);
    rdChk("R12 ecc status masked", 32'h98);
    wrReg(32'h98, 32'h0010_0000);
    #1; chk("R12 irq rises", 32'(eccIrq), 32'h1);
    wrReg(32'h98, 32'hFFFF_FFFF);
    #1; chk("R12 irq stays", 32'(eccIrq), 32'h1);
    wrReg(32'h98, 32'h0);
    #1; chk("R12 irq falls", 32'(eccIrq), 32'h0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [31:0] off, v;
      op  = int'($urandom_range(0, 3));
      off = offs[$urandom_range(0, 14)];
      v   = $urandom;
      if (op == 0) begin
        if (off >= 32'h40 && off <= 32'h4C) v = (v & 32'h07FF_FFFF) | 32'h1;
        if (off == 32'h20 && $urandom_range(0, 3) != 0) v = v | 32'h8000_0000;
        wrReg(off, v);
        #1; chk("R12 irq random", 32'(eccIrq), 32'(mIrq));
      end else if (op == 1) begin
        rdChk("R1 R8 random read", off);
      end else begin
        hitChk("R10 R11 random decode", $urandom & 32'h07FF_FFFF);
      end
    end

    summary();
    $finish;
  end
endmodule